// File: doc/BRIEF.md
# I/O Remapping Unit Command and Status Register File

This block is the register front end of an I/O address remapping unit. Software reads and writes it over a plain 64-bit memory-mapped bus: one write or one read per cycle, with a byte address whose low three bits are ignored. Read data is combinational from the address. Reads have no side effects.

The command register stores nothing. Each bit written to it starts an internal operation: enable or disable translation, install the root-table pointer, or flush the write buffer. Software learns that an operation has finished by polling the status register. Two further registers, one for the context cache and one for the IOTLB, start an invalidation when their top bit is written as 1. Hardware clears that bit once the invalidation is done.

Each operation runs in a stub sequencer that simply counts its own latency, set by a parameter in cycles. While an operation is busy, a second request for that same operation is ignored. The capability and extended-capability registers are read-only and are built from parameters.

Top module: `rmu_cmd_regs`

## Requirements
- R1: Writing the command register (byte offset 0x10) with bit 31 different from status bit 31 starts a translation change. Status bit 31 (status register at byte offset 0x18) takes the written value exactly LAT_TE cycles after the write edge. Writing 1 enables translation and writing 0 disables it.
- R2: The root-table address register (offset 0x20) stores bits 63:12 of the written value; bits 11:0 read as 0. Writing command bit 30 clears status bit 30 on the next cycle and captures the root address held at that moment. LAT_ROOT cycles after the write, the active root pointer (read-only, offset 0x28) takes the captured value and status bit 30 becomes 1.
- R3: Writing command bit 27 makes status bit 27 read 1 for exactly LAT_WBF cycles starting after the write edge; after that it reads 0.
- R4: The context-command register (offset 0x30) stores all 64 written bits; bits 62:61 hold the granularity, and 1 means global. Writing bit 63 as 1 starts an invalidation. Bit 63 reads 1 until LAT_CC cycles after the write, then reads 0, while the other bits are kept.
- R5: The IOTLB register sits at byte offset IRO_UNITS*16+8, which is 0x58 by default. It keeps only bit 63 (start), bits 61:60 (granularity: 1 global, 2 domain, 3 page), bits 49:48 (drain reads, drain writes) and bits 47:32 (domain ID); every other bit reads 0. Bit 63 clears itself LAT_IOTLB cycles after it was written as 1.
- R6: The capability register (offset 0x00) is read-only. It holds the domain-count code in bits 2:0, the write-buffer-flush-required flag at bit 4, caching mode at bit 7, supported address widths in bits 12:8 and superpage support in bits 37:34; all other bits are 0.
- R7: The extended-capability register (offset 0x08) is read-only. It holds coherency at bit 0, pass-through support at bit 2 and IRO_UNITS in bits 17:8; all other bits are 0.
- R8: The command register reads as 0. Reserved offsets, including IRO_UNITS*16, read 0, and writes to them change no readable state.
- R9: While an operation is busy, a new request for that same operation is ignored and its latency is not restarted. While an invalidation is busy, a write to its register is dropped entirely.
- R10: After reset, the status, root address, active root, context-command and IOTLB registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Byte address; bits 2:0 ignored |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for addr, combinational |

## Verification
The assertions assume that the bus carries at most one access per cycle and that software never addresses a register through the unaligned low address bits. They also assume every latency parameter is at least 1 and that the IOTLB offset does not collide with another register. The stimulus keeps to these by issuing only aligned, single-cycle writes separated by idle cycles, with the default parameters. The reference model predicts the status word on every idle cycle, including cycles where a repeated request lands while the same operation is still busy.

// File: rtl/rmu_pkg.sv
// Package: shared constants, register selector type and capability builders
// for the remapping unit register file. Assumes a 64-bit data bus.
package rmu_pkg;

    localparam int unsigned DATA_W   = 64;
    localparam int unsigned ROOT_LSB = 12;

    // Word indices (byte offset / 8) of the fixed registers.
    localparam int unsigned WORD_CAP    = 0;
    localparam int unsigned WORD_ECAP   = 1;
    localparam int unsigned WORD_CMD    = 2;
    localparam int unsigned WORD_STAT   = 3;
    localparam int unsigned WORD_ROOT   = 4;
    localparam int unsigned WORD_ACTIVE = 5;
    localparam int unsigned WORD_CTX    = 6;

    // Command and status bit positions.
    localparam int unsigned BIT_TE   = 31;
    localparam int unsigned BIT_ROOT = 30;
    localparam int unsigned BIT_WBF  = 27;
    localparam int unsigned BIT_GO   = 63;

    // Bits kept by the IOTLB register: go, granularity, drains, domain ID.
    localparam logic [DATA_W-1:0] IOTLB_KEEP = 64'hB003_FFFF_0000_0000;

    typedef enum logic [2:0] {
        SEL_CAP, SEL_ECAP, SEL_CMD, SEL_STAT,
        SEL_ROOT, SEL_ACTIVE, SEL_CTX, SEL_IOTLB
    } reg_sel_e;

    localparam int unsigned N_SEL = 8;

    // Builds the read-only capability word from its fields.
    function automatic logic [DATA_W-1:0] build_cap(
        input logic [2:0] dom_code,
        input logic       flush_req,
        input logic       cache_mode,
        input logic [4:0] widths,
        input logic [3:0] big_pages
    );
        logic [DATA_W-1:0] v;
        v        = '0;
        v[2:0]   = dom_code;
        v[4]     = flush_req;
        v[7]     = cache_mode;
        v[12:8]  = widths;
        v[37:34] = big_pages;
        return v;
    endfunction

    // Builds the read-only extended-capability word from its fields.
    function automatic logic [DATA_W-1:0] build_ecap(
        input logic       coherent,
        input logic       pass_thru,
        input logic [9:0] iro
    );
        logic [DATA_W-1:0] v;
        v       = '0;
        v[0]    = coherent;
        v[2]    = pass_thru;
        v[17:8] = iro;
        return v;
    endfunction

endpackage

// File: rtl/rmu_addr_dec.sv
// Module: address decoder. Maps a word address onto a one-hot register
// select, or all zeros for a reserved offset. Assumes the IOTLB word does
// not coincide with one of the fixed register words.
module rmu_addr_dec
    import rmu_pkg::*;
#(
    parameter int unsigned WORD_W     = 9,
    parameter int unsigned IOTLB_WORD = 11
) (
    input  logic [WORD_W-1:0] word,
    output logic [N_SEL-1:0]  sel
);

    localparam logic [WORD_W-1:0] W_CAP    = WORD_W'(WORD_CAP);
    localparam logic [WORD_W-1:0] W_ECAP   = WORD_W'(WORD_ECAP);
    localparam logic [WORD_W-1:0] W_CMD    = WORD_W'(WORD_CMD);
    localparam logic [WORD_W-1:0] W_STAT   = WORD_W'(WORD_STAT);
    localparam logic [WORD_W-1:0] W_ROOT   = WORD_W'(WORD_ROOT);
    localparam logic [WORD_W-1:0] W_ACTIVE = WORD_W'(WORD_ACTIVE);
    localparam logic [WORD_W-1:0] W_CTX    = WORD_W'(WORD_CTX);
    localparam logic [WORD_W-1:0] W_IOTLB  = WORD_W'(IOTLB_WORD);

    // Purpose: pick at most one register for the current word address.
    always_comb begin
        sel = '0;
        if (word == W_IOTLB) begin
            sel[SEL_IOTLB] = 1'b1;
        end else begin
            case (word)
                W_CAP:    sel[SEL_CAP]    = 1'b1;
                W_ECAP:   sel[SEL_ECAP]   = 1'b1;
                W_CMD:    sel[SEL_CMD]    = 1'b1;
                W_STAT:   sel[SEL_STAT]   = 1'b1;
                W_ROOT:   sel[SEL_ROOT]   = 1'b1;
                W_ACTIVE: sel[SEL_ACTIVE] = 1'b1;
                W_CTX:    sel[SEL_CTX]    = 1'b1;
                default:  sel = '0;
            endcase
        end
    end

endmodule

// File: rtl/rmu_op_seq.sv
// Module: stub operation sequencer. A start while idle makes it busy for
// exactly LATENCY cycles; done pulses in the last busy cycle. A start while
// busy is ignored. Assumes LATENCY >= 1.
module rmu_op_seq #(
    parameter int unsigned LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == CNT_W'(1));

    // Purpose: load the latency on an accepted start, count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(LATENCY);
        end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    AST_SEQ_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && cnt == $past(cnt) - 1'b1)); // R9

    AST_SEQ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

endmodule

// File: rtl/rmu_cmd_regs.sv
// Module: command/status register file of an I/O address remapping unit.
// Command bits are not stored; each starts an operation in a stub sequencer
// whose completion shows up in the status register or as a self-clearing
// go bit. Assumes one bus access per cycle and aligned addresses.
module rmu_cmd_regs
    import rmu_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned IRO_UNITS  = 5,
    parameter logic [2:0]  DOM_CODE   = 3'd2,
    parameter logic        FLUSH_REQ  = 1'b1,
    parameter logic        CACHE_MODE = 1'b0,
    parameter logic [4:0]  WIDTHS     = 5'b00100,
    parameter logic [3:0]  BIG_PAGES  = 4'b0011,
    parameter logic        COHERENT   = 1'b1,
    parameter logic        PASS_THRU  = 1'b1,
    parameter int unsigned LAT_TE     = 4,
    parameter int unsigned LAT_ROOT   = 3,
    parameter int unsigned LAT_WBF    = 5,
    parameter int unsigned LAT_CC     = 6,
    parameter int unsigned LAT_IOTLB  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata
);

    localparam int unsigned WORD_W     = ADDR_W - 3;
    localparam int unsigned IOTLB_WORD = (IRO_UNITS * 16 + 8) / 8;
    localparam logic [DATA_W-1:0] CAP_VAL =
        build_cap(DOM_CODE, FLUSH_REQ, CACHE_MODE, WIDTHS, BIG_PAGES);
    localparam logic [DATA_W-1:0] ECAP_VAL =
        build_ecap(COHERENT, PASS_THRU, 10'(IRO_UNITS));

    logic [N_SEL-1:0] sel;

    logic te_start, te_busy, te_done;
    logic root_start, root_busy, root_done;
    logic wbf_start, wbf_busy, wbf_done;
    logic cc_start, cc_busy, cc_done;
    logic iq_start, iq_busy, iq_done;

    logic                       stat_te, te_target, stat_rtp;
    logic [DATA_W-1:ROOT_LSB]   root_addr, root_pend, root_active;
    logic [DATA_W-1:0]          ctx_q, iotlb_q;
    logic                       wr_cmd, wr_ctx, wr_iq;
    logic                       unused_bits;

    rmu_addr_dec #(
        .WORD_W     (WORD_W),
        .IOTLB_WORD (IOTLB_WORD)
    ) i_dec (
        .word (addr[ADDR_W-1:3]),
        .sel  (sel)
    );

    assign wr_cmd = wr_en && sel[SEL_CMD];
    assign wr_ctx = wr_en && sel[SEL_CTX];
    assign wr_iq  = wr_en && sel[SEL_IOTLB];

    assign te_start   = wr_cmd && (wdata[BIT_TE] != stat_te) && !te_busy;
    assign root_start = wr_cmd && wdata[BIT_ROOT] && !root_busy;
    assign wbf_start  = wr_cmd && wdata[BIT_WBF] && !wbf_busy;
    assign cc_start   = wr_ctx && wdata[BIT_GO] && !cc_busy;
    assign iq_start   = wr_iq && wdata[BIT_GO] && !iq_busy;

    rmu_op_seq #(.LATENCY(LAT_TE)) i_seq_te (
        .clk(clk), .rst_n(rst_n), .start(te_start), .busy(te_busy), .done(te_done));
    rmu_op_seq #(.LATENCY(LAT_ROOT)) i_seq_root (
        .clk(clk), .rst_n(rst_n), .start(root_start), .busy(root_busy), .done(root_done));
    rmu_op_seq #(.LATENCY(LAT_WBF)) i_seq_wbf (
        .clk(clk), .rst_n(rst_n), .start(wbf_start), .busy(wbf_busy), .done(wbf_done));
    rmu_op_seq #(.LATENCY(LAT_CC)) i_seq_cc (
        .clk(clk), .rst_n(rst_n), .start(cc_start), .busy(cc_busy), .done(cc_done));
    rmu_op_seq #(.LATENCY(LAT_IOTLB)) i_seq_iq (
        .clk(clk), .rst_n(rst_n), .start(iq_start), .busy(iq_busy), .done(iq_done));

    assign unused_bits = ^{addr[2:0], wbf_done};

    // Purpose: record the requested translation state and apply it on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            te_target <= 1'b0;
            stat_te   <= 1'b0;
        end else begin
            if (te_start) begin
                te_target <= wdata[BIT_TE];
            end
            if (te_done) begin
                stat_te <= te_target;
            end
        end
    end

    // Purpose: hold the programmed root-table address (page aligned).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_addr <= '0;
        end else if (wr_en && sel[SEL_ROOT]) begin
            root_addr <= wdata[DATA_W-1:ROOT_LSB];
        end
    end

    // Purpose: capture the root address at command time, install it on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_pend   <= '0;
            root_active <= '0;
            stat_rtp    <= 1'b0;
        end else begin
            if (root_start) begin
                root_pend <= root_addr;
                stat_rtp  <= 1'b0;
            end
            if (root_done) begin
                root_active <= root_pend;
                stat_rtp    <= 1'b1;
            end
        end
    end

    // Purpose: context-command register, dropped while busy, go bit self-clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (wr_ctx && !cc_busy) begin
            ctx_q <= wdata;
        end else if (cc_done) begin
            ctx_q[BIT_GO] <= 1'b0;
        end
    end

    // Purpose: IOTLB register, keeps defined fields only, go bit self-clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iotlb_q <= '0;
        end else if (wr_iq && !iq_busy) begin
            iotlb_q <= wdata & IOTLB_KEEP;
        end else if (iq_done) begin
            iotlb_q[BIT_GO] <= 1'b0;
        end
    end

    // Purpose: read multiplexer; reserved offsets and the command register read 0.
    always_comb begin
        rdata = '0;
        if (sel[SEL_CAP])    rdata = CAP_VAL;
        if (sel[SEL_ECAP])   rdata = ECAP_VAL;
        if (sel[SEL_STAT])   rdata = {32'd0, stat_te, stat_rtp, 2'b00, wbf_busy, 27'd0};
        if (sel[SEL_ROOT])   rdata = {root_addr, 12'd0};
        if (sel[SEL_ACTIVE]) rdata = {root_active, 12'd0};
        if (sel[SEL_CTX])    rdata = ctx_q;
        if (sel[SEL_IOTLB])  rdata = iotlb_q;
    end

    AST_TE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !te_done |=> $stable(stat_te)); // R1

    AST_TE_TAKES_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        te_done |=> (stat_te == $past(te_target))); // R1

    AST_ROOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        root_start |=> !stat_rtp); // R2

    AST_ROOT_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        root_done |=> (stat_rtp && root_active == $past(root_pend))); // R2

    AST_WBF_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[BIT_WBF] && !wbf_busy) |=> wbf_busy); // R3

    AST_CTX_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cc_done |=> !ctx_q[BIT_GO]); // R4

    AST_IOTLB_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        iq_done |=> !iotlb_q[BIT_GO]); // R5

    AST_IOTLB_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (iotlb_q & ~IOTLB_KEEP) == '0); // R5

    AST_CTX_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_busy && !cc_done) |=> $stable(ctx_q)); // R9

endmodule

// File: tb/test_rmu_cmd_regs.sv
`timescale 1ns/100ps
// Bench: behavioural reference model of the register file, stepped on every
// clock edge; the status word is compared on every idle cycle.
module test_rmu_cmd_regs;

    localparam int LT = 4, LR = 3, LW = 5, LC = 6, LI = 7, IRO = 5;
    localparam logic [11:0] A_CAP = 12'h000, A_ECAP = 12'h008, A_CMD = 12'h010,
                            A_STAT = 12'h018, A_ROOT = 12'h020, A_ACT = 12'h028,
                            A_CTX = 12'h030, A_IQ = 12'(IRO * 16 + 8);

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [11:0] addr = A_STAT;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;

    int total = 0, bad = 0;

    // reference model state
    int          te_cnt = 0, rt_cnt = 0, wb_cnt = 0, cc_cnt = 0, iq_cnt = 0;
    logic        m_te = 0, te_tgt = 0, m_rtp = 0;
    logic [63:0] m_root = 0, m_pend = 0, m_act = 0, m_ctx = 0, m_iq = 0;

    always #2.5 clk = ~clk;

    rmu_cmd_regs #(
        .ADDR_W(12), .IRO_UNITS(IRO), .DOM_CODE(3'd2), .FLUSH_REQ(1'b1),
        .CACHE_MODE(1'b0), .WIDTHS(5'b00100), .BIG_PAGES(4'b0011),
        .COHERENT(1'b1), .PASS_THRU(1'b1), .LAT_TE(LT), .LAT_ROOT(LR),
        .LAT_WBF(LW), .LAT_CC(LC), .LAT_IOTLB(LI)
    ) i_rmu_cmd_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [63:0] exp_stat();
        logic [63:0] v = '0;
        v[31] = m_te;
        v[30] = m_rtp;
        v[27] = (wb_cnt > 0);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model of one clock edge, using the inputs applied in this cycle
    task automatic model_edge();
        int te0 = te_cnt, rt0 = rt_cnt, wb0 = wb_cnt, cc0 = cc_cnt, iq0 = iq_cnt;
        if (!rst_n) begin
            te_cnt = 0; rt_cnt = 0; wb_cnt = 0; cc_cnt = 0; iq_cnt = 0;
            m_te = 0; te_tgt = 0; m_rtp = 0;
            m_root = 0; m_pend = 0; m_act = 0; m_ctx = 0; m_iq = 0;
            return;
        end
        if (te0 == 1) m_te = te_tgt;
        if (rt0 == 1) begin m_act = m_pend; m_rtp = 1; end
        if (cc0 == 1) m_ctx[63] = 0;
        if (iq0 == 1) m_iq[63] = 0;
        if (te_cnt > 0) te_cnt--;
        if (rt_cnt > 0) rt_cnt--;
        if (wb_cnt > 0) wb_cnt--;
        if (cc_cnt > 0) cc_cnt--;
        if (iq_cnt > 0) iq_cnt--;
        if (wr_en) begin
            if (addr == A_CMD) begin
                if (te0 == 0 && wdata[31] != m_te) begin te_cnt = LT; te_tgt = wdata[31]; end
                if (rt0 == 0 && wdata[30]) begin rt_cnt = LR; m_pend = m_root; m_rtp = 0; end
                if (wb0 == 0 && wdata[27]) wb_cnt = LW;
            end else if (addr == A_ROOT) begin
                m_root = {wdata[63:12], 12'h000};
            end else if (addr == A_CTX) begin
                if (cc0 == 0) begin m_ctx = wdata; if (wdata[63]) cc_cnt = LC; end
            end else if (addr == A_IQ) begin
                if (iq0 == 0) begin
                    m_iq = wdata & 64'hB003_FFFF_0000_0000;
                    if (wdata[63]) iq_cnt = LI;
                end
            end
        end
    endtask

    // one clock: model the edge, then compare status on idle cycles
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (addr == A_STAT) chk("R1/R2/R3 status word", rdata, exp_stat());
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0; addr = A_STAT; wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [63:0] exp);
        addr = a;
        #0.5;
        chk(tag, rdata, exp);
        addr = A_STAT;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R10: reset state
        rd("R10 status", A_STAT, 64'h0);
        rd("R10 root", A_ROOT, 64'h0);
        rd("R10 active", A_ACT, 64'h0);
        rd("R10 ctx", A_CTX, 64'h0);
        rd("R10 iotlb", A_IQ, 64'h0);
        // R6/R7: capability layouts, read-only
        rd("R6 cap", A_CAP, 64'h0000_000C_0000_0412);
        rd("R7 ecap", A_ECAP, 64'h0000_0000_0000_0505);
        wr(A_CAP, '1);
        rd("R6 cap after write", A_CAP, 64'h0000_000C_0000_0412);
        wr(A_ECAP, '1);
        rd("R7 ecap after write", A_ECAP, 64'h0000_0000_0000_0505);
        // R8: command reads 0, reserved offsets dropped
        rd("R8 cmd reads zero", A_CMD, 64'h0);
        wr(12'h040, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R8 reserved 0x40", 12'h040, 64'h0);
        rd("R8 reserved iro*16", 12'(IRO * 16), 64'h0);
        wr(12'hFF8, 64'h1234);
        rd("R8 reserved 0xff8", 12'hFF8, 64'h0);
        rd("R8 ctx untouched", A_CTX, 64'h0);
        // R2: root address and pointer install
        wr(A_ROOT, 64'h0000_0012_3456_7ABC);
        rd("R2 root aligned", A_ROOT, 64'h0000_0012_3456_7000);
        wr(A_CMD, 64'h4000_0000);
        wr(A_ROOT, 64'h0000_00AB_CDEF_0000);
        idle(LR);
        rd("R2 active captured", A_ACT, 64'h0000_0012_3456_7000);
        chk("R2 model active", m_act, 64'h0000_0012_3456_7000);
        wr(A_CMD, 64'h4000_0000);
        idle(LR + 1);
        rd("R2 active second", A_ACT, 64'h0000_00AB_CDEF_0000);
        // R1/R9: enable, repeated and opposite requests while busy ignored
        wr(A_CMD, 64'h8000_0000);
        idle(1);
        wr(A_CMD, 64'h0);
        idle(LT);
        rd("R1 enabled", A_STAT, 64'h8000_0000 | (m_rtp ? 64'h4000_0000 : 64'h0));
        wr(A_CMD, 64'h0);
        idle(LT + 1);
        chk("R1 disabled", m_te, 1'b0);
        // R3/R9: write-buffer flush, repeat while busy does not restart
        wr(A_CMD, 64'h0800_0000);
        idle(2);
        wr(A_CMD, 64'h0800_0000);
        idle(LW);
        // all three command bits in one write
        wr(A_CMD, 64'hC800_0000);
        idle(LW + 2);
        rd("R1 R2 R3 combined", A_STAT, 64'hC000_0000);
        // R4/R9: context invalidation
        wr(A_CTX, 64'hA000_0000_0000_1234);
        rd("R4 go visible", A_CTX, 64'hA000_0000_0000_1234);
        wr(A_CTX, 64'h0000_0000_0000_5555);
        rd("R9 ctx write dropped", A_CTX, 64'hA000_0000_0000_1234);
        idle(LC);
        rd("R4 go cleared", A_CTX, 64'h2000_0000_0000_1234);
        wr(A_CTX, 64'h4000_0000_0000_0077);
        rd("R4 store no go", A_CTX, 64'h4000_0000_0000_0077);
        // R5: IOTLB fields and self clear
        wr(A_IQ, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R5 masked", A_IQ, 64'hB003_FFFF_0000_0000);
        idle(LI);
        rd("R5 go cleared", A_IQ, 64'h3003_FFFF_0000_0000);
        wr(A_IQ, 64'hA000_0005_0000_0000);
        wr(A_IQ, 64'h9000_0000_0000_0000);
        rd("R9 iotlb write dropped", A_IQ, 64'hA000_0005_0000_0000);
        idle(LI);
        rd("R5 domain kept", A_IQ, 64'h2000_0005_0000_0000);
        rd("R5 model agrees", A_IQ, m_iq);
        idle(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule